// File: doc/BRIEF.md
# Indexed Configuration Register Hub

This block is the primary configuration register file of a small system chip. Software reaches it through two fixed I/O ports. A byte written to port 22h selects a register. Port 23h then reads or writes the selected register. Some register bits are hard-wired to zero by fixed write masks. Indices from C0h upward do not belong to this block: a read there returns FFh and raises a "not claimed" flag, so that another responder can answer.

Two further register windows can be placed anywhere in I/O space. These are a host-bus window and a local-bus window, each holding 256 bytes and each five ports wide. Register 10h selects which window a base write relocates. Byte writes to indices 12h and 13h then set that window's base. The block also turns a group of bit-pair registers into per-region internal read and write enables for the upper memory area. It also produces a system-management RAM enable and two summary flags for BIOS-area shadowing. The memory accesses themselves are handled elsewhere.

Top module: `cfg_hub`

## Requirements
- R1: A write to port 22h loads the index. A read at 22h returns the index. A read or write at 23h reaches the register at the current index.
- R2: Data writes are ANDed with a fixed per-index mask: 21h with FEh, 22h with 7Fh, 28h with E3h, 29h with 0Fh and 36h with 3Fh. All other indices below C0h store all eight bits.
- R3: After reset every register reads 00h except index 7Bh, which reads FFh. The index is 00h, both window bases are 0000h, and all region enables, the system-management RAM enable and the shadow flags are low.
- R4: While the index is C0h or above, a read at 23h returns FFh with `io_unclaimed` high. A write at 23h is not stored and is also flagged unclaimed.
- R5: When register 10h holds 07h, a write to index 12h sets the low byte of the host window base and a write to index 13h sets its high byte. When register 10h holds 06h, the same writes set the local window base. Any other value of register 10h leaves both bases unchanged.
- R6: A window occupies base+0 to base+4. base+0 is that window's index (read and write) and base+4 is its data port for the selected window byte. Reads at base+1 to base+3 return FFh and are claimed. An access outside every span, other than to 22h or 23h, is unclaimed and reads FFh.
- R7: A window whose base is 0000h claims no port.
- R8: Registers 25h, 26h and 27h hold four bit pairs each and cover twelve 16 KB blocks in order from C0000h. Block b is controlled by register 25h+b/4, pair b mod 4. The even bit of the pair sets `wr_internal[b]` and the odd bit sets `rd_internal[b]`; a clear bit means external access.
- R9: Bits 0 and 1 of register 28h drive `wr_internal[12]` and `rd_internal[12]`, which cover the 64 KB region at F0000h. Bit 7 of register 28h drives `smram_en`, which covers 128 KB at A0000h.
- R10: `bios_shadow_rd` is high when any read enable of blocks 8 to 12 (E0000h upward) is set. `bios_shadow_wr` is the same for the write enables.
- R11: Ports 22h and 23h take priority over both windows. Where the two windows overlap, the host window takes priority over the local window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational from address and state |
| io_unclaimed | output | 1 | Access not answered by this block |
| rd_internal | output | 13 | Internal-read enable per region (12 blocks of 16 KB, then F0000h) |
| wr_internal | output | 13 | Internal-write enable per region |
| smram_en | output | 1 | System-management RAM enable |
| bios_shadow_rd | output | 1 | Any read shadow enabled at E0000h or above |
| bios_shadow_wr | output | 1 | Any write shadow enabled at E0000h or above |

## Verification
The assertions assume that read and write strobes are never raised together. They also assume that each strobe is sampled on one clock edge, so that a write changes state exactly one cycle before the outputs that depend on it are checked. The bench issues every access through tasks that raise exactly one strobe for one cycle. The random stimulus draws window bases from a low I/O range that sometimes covers 22h and 23h and sometimes makes the windows overlap, so the priority rules are exercised. A reference model in the bench tracks the index, the masked registers, both bases and both window arrays, and predicts every read and every region output.

// File: rtl/cfg_hub_pkg.sv
// Shared constants and the fixed write-mask function of the config hub.
// Assumes an 8-bit register index and 16-bit I/O addresses.
package cfg_hub_pkg;
    localparam logic [15:0] PORT_INDEX   = 16'h0022;
    localparam logic [15:0] PORT_DATA    = 16'h0023;
    localparam logic [7:0]  FIRST_FOREIGN = 8'hC0;
    localparam logic [7:0]  IDX_SELECT   = 8'h10;
    localparam logic [7:0]  IDX_BASE_LO  = 8'h12;
    localparam logic [7:0]  IDX_BASE_HI  = 8'h13;
    localparam logic [7:0]  SEL_HOST     = 8'h07;
    localparam logic [7:0]  SEL_LOCAL    = 8'h06;
    localparam logic [7:0]  IDX_SHADOW0  = 8'h25;
    localparam logic [7:0]  IDX_ONES     = 8'h7B;

    // Bits software may set at a given index.
    function automatic logic [7:0] write_mask(input logic [7:0] idx);
        case (idx)
            8'h21:   write_mask = 8'hFE;
            8'h22:   write_mask = 8'h7F;
            8'h28:   write_mask = 8'hE3;
            8'h29:   write_mask = 8'h0F;
            8'h36:   write_mask = 8'h3F;
            default: write_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cfg_main_regs.sv
// Main index/data register file. It holds the index, the masked registers
// below FIRST_FOREIGN and the two window bases relocated through 12h/13h.
// Assumes at most one of idx_wr/data_wr per cycle.
module cfg_main_regs
    import cfg_hub_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 192,
    parameter int SH_REGS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idx_wr,
    input  logic                    data_wr,
    input  logic [7:0]              wdata,
    output logic [7:0]              cur_idx,
    output logic                    idx_valid,
    output logic [7:0]              rd_data,
    output logic [ADDR_W-1:0]       host_base,
    output logic [ADDR_W-1:0]       local_base,
    output logic [SH_REGS-1:0][7:0] sh_regs
);
    logic [7:0] regs [0:NUM_REGS-1];

    assign idx_valid = cur_idx < 8'(NUM_REGS);
    assign rd_data   = idx_valid ? regs[cur_idx] : 8'hFF;

    // Expose the shadow bit-pair registers to the decoder.
    for (genvar k = 0; k < SH_REGS; k++) begin : g_sh
        assign sh_regs[k] = regs[int'(IDX_SHADOW0) + k];
    end

    // Index, register store and window base relocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx    <= 8'h00;
            host_base  <= '0;
            local_base <= '0;
            for (int k = 0; k < NUM_REGS; k++)
                regs[k] <= (k == int'(IDX_ONES)) ? 8'hFF : 8'h00;
        end else begin
            if (idx_wr)
                cur_idx <= wdata;
            if (data_wr && idx_valid) begin
                regs[cur_idx] <= wdata & write_mask(cur_idx);
                if (cur_idx == IDX_BASE_LO) begin
                    if (regs[IDX_SELECT] == SEL_HOST)
                        host_base[7:0] <= wdata;
                    else if (regs[IDX_SELECT] == SEL_LOCAL)
                        local_base[7:0] <= wdata;
                end
                if (cur_idx == IDX_BASE_HI) begin
                    if (regs[IDX_SELECT] == SEL_HOST)
                        host_base[ADDR_W-1:8] <= wdata;
                    else if (regs[IDX_SELECT] == SEL_LOCAL)
                        local_base[ADDR_W-1:8] <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_io_window.sv
// Relocatable index/data window of SPAN ports over a DEPTH-byte store.
// base+0 is the window index, base+SPAN-1 the data port; others read FFh.
// Assumes wr_en is already qualified by the caller's priority decode.
module cfg_io_window #(
    parameter int ADDR_W = 16,
    parameter int SPAN   = 5,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic              hit,
    output logic [7:0]        rdata
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] SPAN_W = ADDR_W'(SPAN);
    localparam logic [ADDR_W-1:0] DATA_OFF = ADDR_W'(SPAN - 1);

    logic [ADDR_W-1:0] off;
    logic [IW-1:0]     widx;
    logic [7:0]        store [0:DEPTH-1];

    assign off = io_addr - base;
    assign hit = (base != '0) && (off < SPAN_W);

    // Read mux over the window's ports.
    always_comb begin
        if (off == '0)
            rdata = 8'(widx);
        else if (off == DATA_OFF)
            rdata = store[widx];
        else
            rdata = 8'hFF;
    end

    // Window index and byte store updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx <= '0;
            for (int k = 0; k < DEPTH; k++)
                store[k] <= 8'h00;
        end else if (wr_en) begin
            if (off == '0)
                widx <= wdata[IW-1:0];
            else if (off == DATA_OFF)
                store[widx] <= wdata;
        end
    end
endmodule

// File: rtl/cfg_shadow_map.sv
// Decodes bit-pair shadow registers into per-region internal enables.
// Regions 0..NUM_SMALL-1 are 16 KB blocks, the last region is F0000h.
// Assumes the register after the small-block registers carries the top region
// in pair 0 and the SMRAM enable in bit 7.
module cfg_shadow_map #(
    parameter int SMALL_REGS = 3,
    parameter int PAIRS      = 4,
    parameter int BIOS_FIRST = 8
) (
    input  logic [SMALL_REGS:0][7:0]         sh_regs,
    output logic [SMALL_REGS*PAIRS:0]        rd_int,
    output logic [SMALL_REGS*PAIRS:0]        wr_int,
    output logic                             smram,
    output logic                             bios_rd,
    output logic                             bios_wr
);
    localparam int NUM_SMALL = SMALL_REGS * PAIRS;

    for (genvar b = 0; b < NUM_SMALL; b++) begin : g_blk
        assign wr_int[b] = sh_regs[b / PAIRS][2 * (b % PAIRS)];
        assign rd_int[b] = sh_regs[b / PAIRS][2 * (b % PAIRS) + 1];
    end
    assign wr_int[NUM_SMALL] = sh_regs[SMALL_REGS][0];
    assign rd_int[NUM_SMALL] = sh_regs[SMALL_REGS][1];
    assign smram   = sh_regs[SMALL_REGS][7];
    assign bios_rd = |rd_int[NUM_SMALL:BIOS_FIRST];
    assign bios_wr = |wr_int[NUM_SMALL:BIOS_FIRST];
endmodule

// File: rtl/cfg_hub.sv
// Top of the config hub: fixed index/data ports, two relocatable windows
// (host first, local second) and the shadow-map decode.
// Assumes io_rd and io_wr are never high together.
module cfg_hub
    import cfg_hub_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 192,
    parameter int WIN_SPAN = 5,
    parameter int WIN_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic              io_unclaimed,
    output logic [12:0]       rd_internal,
    output logic [12:0]       wr_internal,
    output logic              smram_en,
    output logic              bios_shadow_rd,
    output logic              bios_shadow_wr
);
    localparam int NWIN = 2;

    logic              hit_idx, hit_dat, main_hit;
    logic [7:0]        cur_idx, main_rd;
    logic              idx_valid;
    logic [ADDR_W-1:0] host_base, local_base;
    logic [ADDR_W-1:0] win_base [NWIN];
    logic [NWIN-1:0]   win_hit, win_sel;
    logic [7:0]        win_rd [NWIN];
    logic [3:0][7:0]   sh_regs;

    assign hit_idx  = io_addr == ADDR_W'(PORT_INDEX);
    assign hit_dat  = io_addr == ADDR_W'(PORT_DATA);
    assign main_hit = hit_idx | hit_dat;

    cfg_main_regs #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SH_REGS(4)) u_main (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(io_wr & hit_idx), .data_wr(io_wr & hit_dat),
        .wdata(io_wdata), .cur_idx(cur_idx), .idx_valid(idx_valid),
        .rd_data(main_rd), .host_base(host_base), .local_base(local_base),
        .sh_regs(sh_regs)
    );

    assign win_base[0] = host_base;
    assign win_base[1] = local_base;

    // Window 0 (host) outranks window 1 (local); main ports outrank both.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        if (w == 0) begin : g_first
            assign win_sel[w] = win_hit[w] & ~main_hit;
        end else begin : g_rest
            assign win_sel[w] = win_hit[w] & ~main_hit & ~(|win_hit[w-1:0]);
        end
        cfg_io_window #(.ADDR_W(ADDR_W), .SPAN(WIN_SPAN), .DEPTH(WIN_DEPTH)) u_win (
            .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .base(win_base[w]),
            .wr_en(io_wr & win_sel[w]), .wdata(io_wdata),
            .hit(win_hit[w]), .rdata(win_rd[w])
        );
    end

    // Read data and claim decode.
    always_comb begin
        io_rdata = 8'hFF;
        if (hit_idx)
            io_rdata = cur_idx;
        else if (hit_dat)
            io_rdata = main_rd;
        else if (win_sel[0])
            io_rdata = win_rd[0];
        else if (win_sel[1])
            io_rdata = win_rd[1];
    end

    assign io_unclaimed = (io_rd | io_wr) &
                          ~(hit_idx | (hit_dat & idx_valid) | (|win_sel));

    cfg_shadow_map #(.SMALL_REGS(3), .PAIRS(4), .BIOS_FIRST(8)) u_map (
        .sh_regs(sh_regs), .rd_int(rd_internal), .wr_int(wr_internal),
        .smram(smram_en), .bios_rd(bios_shadow_rd), .bios_wr(bios_shadow_wr)
    );
endmodule

// File: rtl/cfg_hub_chk.sv
// Property checker for cfg_hub, attached by bind. Observes ports plus the
// current index and window bases held by the main register file.
module cfg_hub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_rdata,
    input logic        io_unclaimed,
    input logic [7:0]  cur_idx,
    input logic [15:0] host_base,
    input logic [15:0] local_base,
    input logic [12:0] wr_internal,
    input logic        smram_en
);
    // R2
    mask21_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h0023 && cur_idx == 8'h21) |=>
        !(io_rd && io_addr == 16'h0023 && cur_idx == 8'h21 && io_rdata[0]));
    // R4
    foreign_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == 16'h0023 && cur_idx >= 8'hC0) |->
        (io_unclaimed && io_rdata == 8'hFF));
    // R6
    host_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && host_base != 16'h0 && io_addr != 16'h0022 && io_addr != 16'h0023 &&
         (io_addr - host_base) >= 16'd1 && (io_addr - host_base) <= 16'd3) |->
        (io_rdata == 8'hFF && !io_unclaimed));
    // R7
    no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && host_base == 16'h0 && local_base == 16'h0 &&
         io_addr != 16'h0022 && io_addr != 16'h0023) |-> io_unclaimed);
    // R8
    blk0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h0023 && cur_idx == 8'h25) |=>
        (wr_internal[0] == $past(io_wdata[0])));
    // R9
    smram_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h0023 && cur_idx == 8'h28) |=>
        (smram_en == $past(io_wdata[7])));
endmodule

bind cfg_hub cfg_hub_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .io_unclaimed(io_unclaimed), .cur_idx(cur_idx), .host_base(host_base),
    .local_base(local_base), .wr_internal(wr_internal), .smram_en(smram_en)
);

// File: tb/cfg_hub_test.sv
`timescale 1ns/1ps
module cfg_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_unclaimed;
    logic [12:0] rd_internal, wr_internal;
    logic        smram_en, bios_shadow_rd, bios_shadow_wr;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_hub uut (.*);

    // Reference model state
    logic [7:0]  m [0:255];
    logic [7:0]  midx;
    logic [15:0] hb, lb;
    logic [7:0]  hidx, lidx;
    logic [7:0]  harr [0:255];
    logic [7:0]  larr [0:255];

    function automatic logic [7:0] mask_of(input logic [7:0] i);
        case (i)
            8'h21: return 8'hFE;
            8'h22: return 8'h7F;
            8'h28: return 8'hE3;
            8'h29: return 8'h0F;
            8'h36: return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit in_win(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        d = a - b;
        return (b != 16'h0) && (d < 16'd5);
    endfunction

    // {unclaimed, data} expected for a read at address a
    function automatic logic [8:0] exp_read(input logic [15:0] a);
        logic [15:0] d;
        if (a == 16'h0022) return {1'b0, midx};
        if (a == 16'h0023) return (midx >= 8'hC0) ? {1'b1, 8'hFF} : {1'b0, m[midx]};
        if (in_win(a, hb)) begin
            d = a - hb;
            if (d == 16'd0) return {1'b0, hidx};
            if (d == 16'd4) return {1'b0, harr[hidx]};
            return {1'b0, 8'hFF};
        end
        if (in_win(a, lb)) begin
            d = a - lb;
            if (d == 16'd0) return {1'b0, lidx};
            if (d == 16'd4) return {1'b0, larr[lidx]};
            return {1'b0, 8'hFF};
        end
        return {1'b1, 8'hFF};
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] v);
        logic [15:0] d;
        if (a == 16'h0022) midx = v;
        else if (a == 16'h0023) begin
            if (midx < 8'hC0) begin
                if (midx == 8'h12 && m[8'h10] == 8'h07) hb[7:0] = v;
                else if (midx == 8'h12 && m[8'h10] == 8'h06) lb[7:0] = v;
                if (midx == 8'h13 && m[8'h10] == 8'h07) hb[15:8] = v;
                else if (midx == 8'h13 && m[8'h10] == 8'h06) lb[15:8] = v;
                m[midx] = v & mask_of(midx);
            end
        end else if (in_win(a, hb)) begin
            d = a - hb;
            if (d == 16'd0) hidx = v; else if (d == 16'd4) harr[hidx] = v;
        end else if (in_win(a, lb)) begin
            d = a - lb;
            if (d == 16'd0) lidx = v; else if (d == 16'd4) larr[lidx] = v;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_wdata = v; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a);
        logic [8:0] e;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        e = exp_read(a);
        chk(req, {23'h0, io_unclaimed, io_rdata}, {23'h0, e});
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    task automatic attr_chk(input string req);
        logic [12:0] er, ew;
        for (int b = 0; b < 12; b++) begin
            ew[b] = m[8'h25 + 8'(b / 4)][2 * (b % 4)];
            er[b] = m[8'h25 + 8'(b / 4)][2 * (b % 4) + 1];
        end
        ew[12] = m[8'h28][0];
        er[12] = m[8'h28][1];
        chk({req, " wr_internal"}, {19'h0, wr_internal}, {19'h0, ew});
        chk({req, " rd_internal"}, {19'h0, rd_internal}, {19'h0, er});
        chk({req, " smram_en"}, {31'h0, smram_en}, {31'h0, m[8'h28][7]});
        chk({req, " bios flags"}, {30'h0, bios_shadow_rd, bios_shadow_wr},
            {30'h0, |er[12:8], |ew[12:8]});
    endtask

    task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
        wr(16'h0022, i);
        wr(16'h0023, v);
    endtask

    task automatic set_base(input logic [7:0] sel, input logic [15:0] b);
        set_reg(8'h10, sel);
        set_reg(8'h12, b[7:0]);
        set_reg(8'h13, b[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int k = 0; k < 256; k++) begin
            m[k] = (k == 8'h7B) ? 8'hFF : 8'h00;
            harr[k] = 8'h00; larr[k] = 8'h00;
        end
        midx = 0; hb = 0; lb = 0; hidx = 0; lidx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: reset state
        rd_chk("R3 index after reset", 16'h0022);
        rd_chk("R3 reg 00h after reset", 16'h0023);
        wr(16'h0022, 8'h7B);
        rd_chk("R3 reg 7Bh resets to FF", 16'h0023);
        attr_chk("R3");
        rd_chk("R3 R7 no window at reset", 16'h0100);

        // R1 / R2: plain and masked registers
        set_reg(8'h40, 8'hC3);
        rd_chk("R1 index readback", 16'h0022);
        rd_chk("R1 data readback", 16'h0023);
        foreach (m[k]) ;
        set_reg(8'h21, 8'hFF); rd_chk("R2 mask 21h", 16'h0023);
        set_reg(8'h22, 8'hFF); rd_chk("R2 mask 22h", 16'h0023);
        set_reg(8'h29, 8'hFF); rd_chk("R2 mask 29h", 16'h0023);
        set_reg(8'h36, 8'hFF); rd_chk("R2 mask 36h", 16'h0023);

        // R4: foreign range
        set_reg(8'hC0, 8'h55); rd_chk("R4 index C0h", 16'h0023);
        set_reg(8'hFF, 8'h55); rd_chk("R4 index FFh", 16'h0023);

        // R5 / R6: host window at 0140h
        set_base(8'h07, 16'h0140);
        wr(16'h0140, 8'h33); wr(16'h0144, 8'hA5);
        rd_chk("R6 host data", 16'h0144);
        rd_chk("R5 R6 host index", 16'h0140);
        rd_chk("R6 gap +1", 16'h0141);
        rd_chk("R6 gap +3", 16'h0143);
        rd_chk("R6 past span", 16'h0145);
        // local window at 0141h overlaps host (R11)
        set_base(8'h06, 16'h0141);
        wr(16'h0145, 8'h77);
        rd_chk("R11 local beyond host", 16'h0145);
        rd_chk("R11 host wins overlap", 16'h0144);
        // other selector leaves bases alone (R5)
        set_base(8'h05, 16'h0300);
        rd_chk("R5 host base unchanged", 16'h0144);
        rd_chk("R5 no window at 0300h", 16'h0300);
        // R11: window placed on the main ports
        set_base(8'h07, 16'h0020);
        rd_chk("R11 main port priority", 16'h0022);
        rd_chk("R11 window +0 at 0020h", 16'h0020);
        // R7: zero base disables
        set_base(8'h07, 16'h0000);
        rd_chk("R7 host disabled", 16'h0020);

        // R8 / R9 / R10: shadow map
        set_reg(8'h25, 8'h5A); attr_chk("R8 reg 25h");
        set_reg(8'h26, 8'hC1); attr_chk("R8 reg 26h");
        set_reg(8'h27, 8'h02); attr_chk("R10 read-only E block");
        set_reg(8'h28, 8'hFF); attr_chk("R9 reg 28h all");
        rd_chk("R2 mask 28h", 16'h0023);
        set_reg(8'h27, 8'h00); set_reg(8'h28, 8'h01); attr_chk("R10 write-only F");
        set_reg(8'h28, 8'h80); attr_chk("R9 smram only");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic [7:0] v;
            logic [15:0] a;
            op = $urandom_range(0, 9);
            v = 8'($urandom);
            case (op)
                0: begin
                    logic [7:0] pick [13];
                    pick = '{8'h10, 8'h12, 8'h13, 8'h21, 8'h22, 8'h25, 8'h26,
                             8'h27, 8'h28, 8'h29, 8'h36, 8'h7B, 8'hC4};
                    a = 16'h0022;
                    v = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pick[$urandom_range(0, 12)];
                    wr(a, v);
                end
                1, 2: begin
                    if (midx == 8'h10) v = 8'($urandom_range(5, 8));
                    if (midx == 8'h13) v = 8'($urandom_range(0, 2));
                    if (midx == 8'h12) v = 8'($urandom_range(0, 255)) & 8'hF3;
                    wr(16'h0023, v);
                end
                3: rd_chk("R1 R4 random main read", 16'h0023);
                4: rd_chk("R1 random index read", 16'h0022);
                5, 6: begin
                    a = (($urandom_range(0, 1) == 0) ? hb : lb) + 16'($urandom_range(0, 5));
                    wr(a, v);
                end
                default: begin
                    a = (($urandom_range(0, 1) == 0) ? hb : lb) + 16'($urandom_range(0, 5));
                    rd_chk("R6 R7 R11 random window read", a);
                end
            endcase
            if (op <= 2) attr_chk("R8 R9 R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule